// File: doc/BRIEF.md
# Masked Latching Interrupt Controller

This block gathers single-cycle event pulses from a port-controller core into two pending registers and turns them into one active-low, open-drain interrupt request. Software reads the pending registers, clears bits by writing ones, and controls two per-bit mask registers and one global mask bit. A small edge detector watches the 2-bit cable orientation status and creates the orientation event. Pending bits always latch, whatever the masks say. The masks only decide whether the pin is pulled low.

The register port is a plain single-cycle access with no back-pressure. A write takes effect at the clock edge where `bus_wr_i` is high. `bus_rdata_o` is a combinational view of the register selected by `bus_addr_i`. The pin is modelled as `irq_pull_o`: when it is 1 the pin is driven low, and when it is 0 the pin is high impedance.

Register addresses: 0 control (bit 0 is the global mask), 1 first mask, 2 second mask, 3 first pending, 4 second pending. Any other address reads 0.

Top module: `pc_irq_ctrl`

## Requirements
- R1: After reset, the global mask reads 1, both mask registers and both pending registers read 0, and `irq_pull_o` is 0.
- R2: An event pulse sets its pending bit at the next clock edge. This happens whatever the global mask and the per-bit masks are set to.
- R3: Writing 1 to a pending bit clears it. Writing 0 leaves it unchanged. Pending bits otherwise hold their value.
- R4: If an event pulse and a write-one-to-clear hit the same bit in the same cycle, the bit stays set.
- R5: `irq_pull_o` is registered. It is 1 one cycle after at least one pending bit is set with its mask bit 0 and the global mask is 0. It returns to 0 one cycle after that condition ends.
- R6: A per-bit mask bit set to 1 keeps its pending bit from driving `irq_pull_o`, but the pending bit still latches and reads back as 1.
- R7: An event latched while the global mask is 1 leaves `irq_pull_o` at 0. `irq_pull_o` becomes 1 one cycle after the global mask is written to 0.
- R8: The orientation event (first pending bit 6) fires only when the orientation status goes from 00 to 01 or from 00 to 10. It does not fire on a change to 11, on a return to 00, or on a change between nonzero codes.
- R9: Reserved bits always read 0 and ignore writes and events. These are bit 7 of the first pending and first mask registers, bits 7 and 4 of the second pending and second mask registers, and bits 7..1 of the control register.
- R10: The first pending register maps `ev0_i[5:0]` to bits 5..0: bit 5 fault, bit 4 bus-voltage change, bit 3 autosink, bit 2 current level, bit 1 detach, bit 0 attach. The second pending register maps `ev1_i` bits to the same positions: bit 6 remedy-vbus-off, bit 5 remedy-vbus-on, bit 3 remedy-fail, bit 2 force-fail, bit 1 force-success, bit 0 remedy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev0_i | input | 6 | Event pulses for first pending bits 5..0 |
| orient_st_i | input | 2 | Orientation status watched by the edge detector |
| ev1_i | input | 8 | Event pulses for second pending bits (reserved positions ignored) |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data of the addressed register |
| irq_pull_o | output | 1 | 1 drives the active-low interrupt pin low, 0 leaves it high impedance |

## Verification
The bench builds the block with its default values: 8-bit registers, a 3-bit address and the two reserved-bit layouts. With these values every live and reserved bit position can be reached through the ports. The directed scenarios cover latching under the global mask, the release of the pin when that mask is cleared, per-bit gating, and the same-cycle set/clear collision. They also run the orientation detector through all its code transitions, so both firing and non-firing cases are seen.

// File: rtl/pc_irq_pkg.sv
package pc_irq_pkg;
  localparam int REG_W  = 8;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL  = 3'd0,
    A_MASK0 = 3'd1,
    A_MASK1 = 3'd2,
    A_PEND0 = 3'd3,
    A_PEND1 = 3'd4
  } reg_addr_e;

  localparam logic [REG_W-1:0] LIVE0 = 8'h7F;
  localparam logic [REG_W-1:0] LIVE1 = 8'h6F;
  localparam int ORIENT_BIT = 6;
  localparam int CORE0_W = 6;
endpackage

// File: rtl/irq_orient_edge.sv
module irq_orient_edge #(
  parameter int ST_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [ST_W-1:0] st_i,
  output logic            evt_o
);
  logic [ST_W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= st_i;
  end

  // leaving the idle code towards exactly one active side
  always_comb begin
    evt_o = (prev_q == '0) && ($countones(st_i) == 1);
  end
endmodule

// File: rtl/irq_pend_reg.sv
module irq_pend_reg #(
  parameter int               W    = 8,
  parameter logic [W-1:0]     LIVE = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_o[i] <= 1'b0;
      else        q_o[i] <= LIVE[i] & ((q_o[i] & ~clr_i[i]) | set_i[i]);
    end
  end
endmodule

// File: rtl/irq_cfg_reg.sv
module irq_cfg_reg #(
  parameter int           W    = 8,
  parameter logic [W-1:0] LIVE = '1,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we_i,
  input  logic [W-1:0] wd_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_o <= INIT & LIVE;
    else if (we_i) q_o <= wd_i & LIVE;
  end
endmodule

// File: rtl/irq_pin_gate.sv
module irq_pin_gate #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pend0_i,
  input  logic [W-1:0] mask0_i,
  input  logic [W-1:0] pend1_i,
  input  logic [W-1:0] mask1_i,
  input  logic         gmask_i,
  output logic         pull_o
);
  logic live_req;

  always_comb begin
    live_req = (|(pend0_i & ~mask0_i)) | (|(pend1_i & ~mask1_i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pull_o <= 1'b0;
    else        pull_o <= live_req & ~gmask_i;
  end
endmodule

// File: rtl/pc_irq_ctrl.sv
module pc_irq_ctrl
  import pc_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CORE0_W-1:0] ev0_i,
  input  logic [1:0]        orient_st_i,
  input  logic [REG_W-1:0]  ev1_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [REG_W-1:0]  bus_wdata_i,
  output logic [REG_W-1:0]  bus_rdata_o,
  output logic              irq_pull_o
);
  logic             orient_evt;
  logic [REG_W-1:0] set0, clr0, clr1;
  logic [REG_W-1:0] pend0_q, pend1_q, mask0_q, mask1_q;
  logic [0:0]       gmask_q;
  logic we_ctrl, we_m0, we_m1, we_p0, we_p1;

  always_comb begin
    we_ctrl = bus_wr_i && (bus_addr_i == A_CTRL);
    we_m0   = bus_wr_i && (bus_addr_i == A_MASK0);
    we_m1   = bus_wr_i && (bus_addr_i == A_MASK1);
    we_p0   = bus_wr_i && (bus_addr_i == A_PEND0);
    we_p1   = bus_wr_i && (bus_addr_i == A_PEND1);
    clr0    = we_p0 ? bus_wdata_i : '0;
    clr1    = we_p1 ? bus_wdata_i : '0;
    set0    = '0;
    set0[CORE0_W-1:0] = ev0_i;
    set0[ORIENT_BIT]  = orient_evt;
  end

  irq_orient_edge #(.ST_W(2)) u_orient (
    .clk(clk), .rst_n(rst_n), .st_i(orient_st_i), .evt_o(orient_evt)
  );

  irq_pend_reg #(.W(REG_W), .LIVE(LIVE0)) u_pend0 (
    .clk(clk), .rst_n(rst_n), .set_i(set0), .clr_i(clr0), .q_o(pend0_q)
  );

  irq_pend_reg #(.W(REG_W), .LIVE(LIVE1)) u_pend1 (
    .clk(clk), .rst_n(rst_n), .set_i(ev1_i), .clr_i(clr1), .q_o(pend1_q)
  );

  irq_cfg_reg #(.W(REG_W), .LIVE(LIVE0), .INIT('0)) u_mask0 (
    .clk(clk), .rst_n(rst_n), .we_i(we_m0), .wd_i(bus_wdata_i), .q_o(mask0_q)
  );

  irq_cfg_reg #(.W(REG_W), .LIVE(LIVE1), .INIT('0)) u_mask1 (
    .clk(clk), .rst_n(rst_n), .we_i(we_m1), .wd_i(bus_wdata_i), .q_o(mask1_q)
  );

  irq_cfg_reg #(.W(1), .LIVE(1'b1), .INIT(1'b1)) u_gmask (
    .clk(clk), .rst_n(rst_n), .we_i(we_ctrl), .wd_i(bus_wdata_i[0:0]), .q_o(gmask_q)
  );

  irq_pin_gate #(.W(REG_W)) u_gate (
    .clk(clk), .rst_n(rst_n),
    .pend0_i(pend0_q), .mask0_i(mask0_q),
    .pend1_i(pend1_q), .mask1_i(mask1_q),
    .gmask_i(gmask_q[0]), .pull_o(irq_pull_o)
  );

  always_comb begin
    bus_rdata_o = '0;
    case (bus_addr_i)
      A_CTRL:  bus_rdata_o[0] = gmask_q[0];
      A_MASK0: bus_rdata_o = mask0_q;
      A_MASK1: bus_rdata_o = mask1_q;
      A_PEND0: bus_rdata_o = pend0_q;
      A_PEND1: bus_rdata_o = pend1_q;
      default: bus_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk
  import pc_irq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [CORE0_W-1:0] ev0_i,
  input logic [1:0]        orient_st_i,
  input logic [REG_W-1:0]  ev1_i,
  input logic              bus_wr_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [REG_W-1:0]  bus_wdata_i,
  input logic              irq_pull_o,
  input logic              orient_evt,
  input logic [REG_W-1:0]  pend0_q,
  input logic [REG_W-1:0]  pend1_q,
  input logic [REG_W-1:0]  mask0_q,
  input logic [REG_W-1:0]  mask1_q,
  input logic              gmask
);
  logic [REG_W-1:0] wipe0, wipe1, hit0, hit1;
  always_comb begin
    wipe0 = (bus_wr_i && bus_addr_i == A_PEND0) ? bus_wdata_i : '0;
    wipe1 = (bus_wr_i && bus_addr_i == A_PEND1) ? bus_wdata_i : '0;
    hit0  = {1'b0, orient_evt, ev0_i};
    hit1  = ev1_i & LIVE1;
  end

  // R3: pending bits not wiped stay set
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(pend0_q) & ~$past(wipe0)) & ~pend0_q) == '0) &&
             ((($past(pend1_q) & ~$past(wipe1)) & ~pend1_q) == '0));

  // R2 / R4: any event sets its bit, even under a wipe
  p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(hit0) & ~pend0_q) == '0) && (($past(hit1) & ~pend1_q) == '0));

  // R7: pin stays released while the global mask is set
  p_gmask_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    gmask |=> !irq_pull_o);

  // R5: unmasked pending with global mask clear pulls the pin next cycle
  p_pin_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!gmask && ((pend0_q & ~mask0_q) != '0)) |=> irq_pull_o);

  // R6: fully masked pending never pulls the pin
  p_mask_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (((pend0_q & ~mask0_q) == '0) && ((pend1_q & ~mask1_q) == '0)) |=> !irq_pull_o);

  // R8: orientation event only towards a single active side
  p_orient_r8: assert property (@(posedge clk) disable iff (!rst_n)
    orient_evt |-> (orient_st_i == 2'b01 || orient_st_i == 2'b10));

  // R9: reserved positions stay zero
  p_resv_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend0_q & ~LIVE0) == '0) && ((pend1_q & ~LIVE1) == '0) &&
    ((mask0_q & ~LIVE0) == '0) && ((mask1_q & ~LIVE1) == '0));
endmodule

bind pc_irq_ctrl irq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ev0_i(ev0_i), .orient_st_i(orient_st_i),
  .ev1_i(ev1_i), .bus_wr_i(bus_wr_i), .bus_addr_i(bus_addr_i),
  .bus_wdata_i(bus_wdata_i), .irq_pull_o(irq_pull_o),
  .orient_evt(orient_evt), .pend0_q(pend0_q), .pend1_q(pend1_q),
  .mask0_q(mask0_q), .mask1_q(mask1_q), .gmask(gmask_q[0])
);

// File: tb/tb_pc_irq_ctrl.sv
module tb_pc_irq_ctrl;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] ev0_i = '0;
  logic [1:0] orient_st_i = '0;
  logic [7:0] ev1_i = '0;
  logic       bus_wr_i = 1'b0;
  logic [2:0] bus_addr_i = '0;
  logic [7:0] bus_wdata_i = '0;
  logic [7:0] bus_rdata_o;
  logic       irq_pull_o;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  pc_irq_ctrl dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    bus_wr_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
    step();
    bus_wr_i = 1'b0; bus_wdata_i = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    bus_addr_i = a;
    #1;
    d = bus_rdata_o;
  endtask

  task automatic pulse0(input logic [5:0] v);
    ev0_i = v; step(); ev0_i = '0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(3'd0, d); check("R1 gmask", d, 8'h01);
    rd(3'd1, d); check("R1 mask0", d, 0);
    rd(3'd2, d); check("R1 mask1", d, 0);
    rd(3'd3, d); check("R1 pend0", d, 0);
    rd(3'd4, d); check("R1 pend1", d, 0);
    check("R1 pin", irq_pull_o, 0);
  endtask

  task automatic t_gmask_latch();
    logic [7:0] d;
    pulse0(6'h01);
    rd(3'd3, d); check("R2 latch under gmask", d, 8'h01);
    step(); check("R7 pin quiet under gmask", irq_pull_o, 0);
    wr(3'd0, 8'h00);
    check("R7 pin one cycle later", irq_pull_o, 0);
    step(); check("R7 pin after gmask clear", irq_pull_o, 1);
  endtask

  task automatic t_w1c();
    logic [7:0] d;
    wr(3'd3, 8'h00);
    rd(3'd3, d); check("R3 write zero keeps", d, 8'h01);
    wr(3'd3, 8'h01);
    rd(3'd3, d); check("R3 write one clears", d, 0);
    check("R5 pin lags clear", irq_pull_o, 1);
    step(); check("R5 pin released", irq_pull_o, 0);
  endtask

  task automatic t_mask();
    logic [7:0] d;
    wr(3'd1, 8'h04);
    pulse0(6'h04);
    rd(3'd3, d); check("R6 masked bit latches", d, 8'h04);
    step(); check("R6 masked pin", irq_pull_o, 0);
    wr(3'd1, 8'h00);
    step(); check("R6 unmask raises pin", irq_pull_o, 1);
    wr(3'd3, 8'h04);
    step(); check("R5 pin drops", irq_pull_o, 0);
  endtask

  task automatic t_collide();
    logic [7:0] d;
    pulse0(6'h02);
    bus_wr_i = 1'b1; bus_addr_i = 3'd3; bus_wdata_i = 8'h02; ev0_i = 6'h02;
    step();
    bus_wr_i = 1'b0; ev0_i = '0;
    rd(3'd3, d); check("R4 set wins", d, 8'h02);
    wr(3'd3, 8'h02);
    rd(3'd3, d); check("R4 cleared after", d, 0);
    step();
  endtask

  task automatic t_orient();
    logic [7:0] d;
    orient_st_i = 2'b01; step();
    rd(3'd3, d); check("R8 00->01 fires", d, 8'h40);
    wr(3'd3, 8'h40);
    orient_st_i = 2'b10; step();
    orient_st_i = 2'b00; step();
    orient_st_i = 2'b11; step();
    orient_st_i = 2'b00; step();
    rd(3'd3, d); check("R8 no fire on 11/return/swap", d, 0);
    orient_st_i = 2'b10; step();
    rd(3'd3, d); check("R8 00->10 fires", d, 8'h40);
    wr(3'd3, 8'h40);
    orient_st_i = 2'b00;
    step(); step();
  endtask

  task automatic t_layout();
    logic [7:0] d;
    ev1_i = 8'hFF; step(); ev1_i = '0;
    rd(3'd4, d); check("R10/R9 pend1 bits", d, 8'h6F);
    pulse0(6'h3F);
    rd(3'd3, d); check("R10 pend0 bits", d, 8'h3F);
    wr(3'd3, 8'hFF);
    rd(3'd3, d); check("R3 all cleared", d, 0);
    wr(3'd1, 8'hFF); rd(3'd1, d); check("R9 mask0 reserved", d, 8'h7F);
    wr(3'd2, 8'hFF); rd(3'd2, d); check("R9 mask1 reserved", d, 8'h6F);
    wr(3'd0, 8'hFE); rd(3'd0, d); check("R9 ctrl reserved", d, 0);
    step(); check("R6 all masked pin", irq_pull_o, 0);
    wr(3'd2, 8'h00);
    step(); check("R5 group1 pin", irq_pull_o, 1);
    wr(3'd4, 8'hFF);
    rd(3'd4, d); check("R3 pend1 cleared", d, 0);
    step(); check("R5 pin released", irq_pull_o, 0);
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_gmask_latch();
    t_w1c();
    t_mask();
    t_collide();
    t_orient();
    t_layout();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule